// File: doc/BRIEF.md
# Memory-Write Packet Register Sink

This block sits on the receive side of a PCIe transaction layer and turns single-doubleword memory writes into register updates. Packets arrive one 32-bit doubleword per beat, framed by valid, start-of-packet and end-of-packet flags. The block walks the three header doublewords and the payload beat. It checks the format, type, length, poison and byte-enable fields as they pass. When a well-formed write lands inside a 256-byte window, it merges the payload into one of 64 registers, one byte at a time.

Anything the block cannot accept is thrown away. Each such packet raises a saturating drop counter by one. A write that is well formed but falls outside the window, or that has no bytes enabled, is ignored quietly and is not counted. Any register can be read at any time through a combinational read port.

Top module: `tlp_reg_sink`

## Requirements
- R1: After reset, every register reads zero and `drop_count` is zero.
- R2: A packet is a header beat 0, a header beat 1, an address beat and a data beat, and it is accepted when all of these hold:
  - header beat 0 has format [30:29] = 2'b10, type [28:24] = 5'b00000, length [9:0] = 1 and poison bit 14 clear;
  - header beat 1 has last byte enables [7:4] = 4'b0000;
  - end-of-packet is on the data beat.

  The write takes effect at the clock edge of the data beat, and `rd_data` shows it from the next cycle on.
- R3: The data word is stored as transmitted, so a write of 0x12345678 reads back as 0x12345678. First byte enable bit 0 (header beat 1, bit 0) gates bits [31:24], bit 1 gates [23:16], bit 2 gates [15:8] and bit 3 gates [7:0]. Lanes that are not enabled keep their old value.
- R4: An accepted write whose first byte enables are 4'b0000 changes no register and does not change `drop_count`.
- R5: The register index is address bits [7:2] of the address beat. A write whose address bits [31:8] differ from `win_base` changes no register and is not counted.
- R6: `drop_count` rises by exactly one for each packet that has any of these faults:
  - a format or type that is not a memory write;
  - a length other than 1;
  - the poison bit set;
  - nonzero last byte enables;
  - end-of-packet on a header or address beat;
  - no end-of-packet on the data beat.

  Such a packet changes no register.
- R7: When the data beat has no end-of-packet, the beats that follow are ignored up to and including the next end-of-packet. After any end-of-packet the block waits for a start-of-packet.
- R8: A start-of-packet that arrives while a packet is still in progress counts the unfinished packet as one drop. The new beat is then parsed as header beat 0 of a fresh packet.
- R9: Cycles with `rx_valid` low leave the parse position unchanged. Beats without start-of-packet that arrive while the block is waiting are ignored.
- R10: `drop_count` saturates at all ones.
- R11: Register contents change only in the cycle after a beat that has both `rx_valid` and `rx_eop` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Beat present on `rx_data` |
| rx_sop | input | 1 | Beat is the first of a packet |
| rx_eop | input | 1 | Beat is the last of a packet |
| rx_data | input | 32 | Packet doubleword |
| win_base | input | 30-$clog2(NUM_REGS) (24) | Address bits [31:8] of the register window |
| rd_addr | input | $clog2(NUM_REGS) (6) | Register read index |
| rd_data | output | 32 | Contents of the indexed register |
| drop_count | output | CNT_W (16) | Saturating count of rejected packets |

## Verification
The assertions assume that `rx_sop`, `rx_eop` and `rx_data` mean something only while `rx_valid` is high. They also assume that `win_base` holds still while a packet is in flight. The stimulus raises the flags only on valid beats and sets the window once, before the first packet. It inserts idle gaps, aborted packets and stray beats only at points where the expected register and counter values can still be worked out from the requirements alone.

// File: rtl/tlp_reg_sink.sv
module tlp_reg_sink #(
  parameter int NUM_REGS = 64,
  parameter int CNT_W    = 16,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int BASE_W  = 30 - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic [31:0]       rx_data,
  input  logic [BASE_W-1:0] win_base,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [31:0]       rd_data,
  output logic [CNT_W-1:0]  drop_count
);

  typedef enum logic [2:0] {S_IDLE, S_H1, S_H2, S_DATA, S_SKIP} state_t;

  state_t           st, nxt;
  logic [31:0]      regs [NUM_REGS];
  logic             hdr_bad, hit, drop, commit;
  logic [3:0]       fbe;
  logic [IDX_W-1:0] idx;

  wire in_pkt = (st == S_H1) || (st == S_H2) || (st == S_DATA);
  wire h0_bad = (rx_data[30:29] != 2'b10) || (rx_data[28:24] != 5'd0) ||
                rx_data[14] || (rx_data[9:0] != 10'd1);

  assign rd_data = regs[rd_addr];

  always_comb begin
    nxt    = st;
    drop   = 1'b0;
    commit = 1'b0;
    if (rx_valid) begin
      if (rx_sop) begin
        drop = in_pkt | rx_eop;
        nxt  = rx_eop ? S_IDLE : S_H1;
      end else begin
        case (st)
          S_H1, S_H2: begin
            drop = rx_eop;
            nxt  = rx_eop ? S_IDLE : ((st == S_H1) ? S_H2 : S_DATA);
          end
          S_DATA: begin
            if (rx_eop) begin
              drop   = hdr_bad;
              commit = !hdr_bad && hit;
              nxt    = S_IDLE;
            end else begin
              drop = 1'b1;
              nxt  = S_SKIP;
            end
          end
          S_SKIP: if (rx_eop) nxt = S_IDLE;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      hdr_bad    <= 1'b0;
      hit        <= 1'b0;
      fbe        <= '0;
      idx        <= '0;
      drop_count <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      st <= nxt;
      if (drop && (drop_count != '1)) drop_count <= drop_count + 1'b1;
      if (rx_valid && rx_sop) begin
        hdr_bad <= h0_bad;
      end else if (rx_valid && st == S_H1) begin
        hdr_bad <= hdr_bad | (rx_data[7:4] != 4'd0);
        fbe     <= rx_data[3:0];
      end else if (rx_valid && st == S_H2) begin
        idx <= rx_data[IDX_W+1:2];
        hit <= (rx_data[31:IDX_W+2] == win_base);
      end
      if (commit)
        for (int b = 0; b < 4; b++)
          if (fbe[b]) regs[idx][31-8*b -: 8] <= rx_data[31-8*b -: 8];
    end
  end

  AST_SOP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_sop && !rx_eop |=> st == S_H1); // R8
  AST_EOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_eop |=> st == S_IDLE); // R7
  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(st) && $stable(drop_count)); // R9
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + 1'b1)); // R6
  AST_DROP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    drop_count == '1 |=> drop_count == '1); // R10
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_eop) ##1 $stable(rd_addr) |-> $stable(rd_data)); // R11

endmodule

// File: tb/test_tlp_reg_sink.sv
module test_tlp_reg_sink;
  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic [31:0] rx_data = '0;
  logic [23:0] win_base = 24'hDC0000;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [CW-1:0] drop_count;

  int checks = 0, errors = 0, exp_drop = 0;
  logic [31:0] model [64];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tlp_reg_sink #(.NUM_REGS(64), .CNT_W(CW)) i_tlp_reg_sink (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
    .rx_data(rx_data), .win_base(win_base), .rd_addr(rd_addr), .rd_data(rd_data),
    .drop_count(drop_count));

  function automatic logic [31:0] h0(input logic [1:0] fmt, input logic [4:0] typ,
                                     input logic ep, input logic [9:0] len);
    return {1'b0, fmt, typ, 8'h00, 1'b0, ep, 4'h0, len};
  endfunction
  function automatic logic [31:0] h1(input logic [3:0] lbe, input logic [3:0] fbe);
    return {24'h000000, lbe, fbe};
  endfunction
  function automatic logic [31:0] ad(input int i);
    return 32'hDC000000 | (i << 2);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input int i);
    rd_addr = i[5:0];
    #0.5;
    check(tag, rd_data, model[i]);
  endtask

  task automatic chk_drop(input string tag);
    check(tag, {28'd0, drop_count}, exp_drop);
  endtask

  task automatic beat(input logic s, input logic e, input logic [31:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_sop = s; rx_eop = e; rx_data = d;
  endtask

  task automatic gap();
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_data = 32'hDEADBEEF;
  endtask

  task automatic pkt(input logic [31:0] a, b, c, d);
    beat(1, 0, a); beat(0, 0, b); beat(0, 0, c); beat(0, 1, d); gap();
  endtask

  task automatic apply(input int i, input logic [3:0] fbe, input logic [31:0] d);
    for (int b = 0; b < 4; b++)
      if (fbe[b]) model[i][31-8*b -: 8] = d[31-8*b -: 8];
  endtask

  task automatic bump();
    if (exp_drop < (1 << CW) - 1) exp_drop++;
  endtask

  task automatic t_reset();
    chk_reg("R1 reg0", 0); chk_reg("R1 reg63", 63); chk_drop("R1 drop");
  endtask

  task automatic t_full_write();
    pkt(h0(2'b10, 5'd0, 0, 10'd1), h1(4'h0, 4'hF), ad(0), 32'h12345678);
    apply(0, 4'hF, 32'h12345678);
    chk_reg("R2 full write", 0); chk_reg("R3 byte order", 0);
    pkt(h0(2'b10, 5'd0, 0, 10'd1), h1(4'h0, 4'hF), ad(63), 32'hCAFEF00D);
    apply(63, 4'hF, 32'hCAFEF00D);
    chk_reg("R5 index 63", 63); chk_reg("R5 reg0 kept", 0); chk_drop("R2 no drop");
  endtask

  task automatic t_lanes();
    pkt(h0(2'b10, 5'd0, 0, 10'd1), h1(4'h0, 4'b0001), ad(0), 32'hAABBCCDD);
    apply(0, 4'b0001, 32'hAABBCCDD);
    chk_reg("R3 lane0 top byte", 0);
    pkt(h0(2'b10, 5'd0, 0, 10'd1), h1(4'h0, 4'b1010), ad(0), 32'h11223344);
    apply(0, 4'b1010, 32'h11223344);
    chk_reg("R3 lanes 1,3", 0);
  endtask

  task automatic t_zero_be();
    pkt(h0(2'b10, 5'd0, 0, 10'd1), h1(4'h0, 4'h0), ad(5), 32'hFFFFFFFF);
    chk_reg("R4 zero enables", 5); chk_drop("R4 not counted");
  endtask

  task automatic t_window();
    pkt(h0(2'b10, 5'd0, 0, 10'd1), h1(4'h0, 4'hF), 32'hDC000100 | (32'd7 << 2), 32'h55555555);
    chk_reg("R5 miss reg7", 7); chk_drop("R5 miss not counted");
  endtask

  task automatic t_bad_headers();
    pkt(h0(2'b10, 5'd0, 0, 10'd2), h1(4'hF, 4'hF), ad(1), 32'h01010101); bump();
    chk_reg("R6 length 2", 1); chk_drop("R6 length 2 count");
    pkt(h0(2'b10, 5'd0, 1, 10'd1), h1(4'h0, 4'hF), ad(1), 32'h02020202); bump();
    chk_reg("R6 poison", 1); chk_drop("R6 poison count");
    pkt(h0(2'b10, 5'b00100, 0, 10'd1), h1(4'h0, 4'hF), ad(1), 32'h03030303); bump();
    chk_reg("R6 wrong type", 1); chk_drop("R6 type count");
    pkt(h0(2'b11, 5'd0, 0, 10'd1), h1(4'h0, 4'hF), ad(1), 32'h04040404); bump();
    chk_drop("R6 wrong format count");
    pkt(h0(2'b10, 5'd0, 0, 10'd1), h1(4'h1, 4'hF), ad(1), 32'h05050505); bump();
    chk_reg("R6 last enables", 1); chk_drop("R6 last enables count");
    beat(1, 0, h0(2'b10, 5'd0, 0, 10'd1)); beat(0, 0, h1(4'h0, 4'hF)); beat(0, 1, ad(1)); gap(); bump();
    chk_drop("R6 early eop count");
  endtask

  task automatic t_missing_eop();
    beat(1, 0, h0(2'b10, 5'd0, 0, 10'd1)); beat(0, 0, h1(4'h0, 4'hF));
    beat(0, 0, ad(2)); beat(0, 0, 32'h66666666);
    beat(0, 0, h0(2'b10, 5'd0, 0, 10'd1)); beat(0, 1, 32'h77777777); gap(); bump();
    chk_reg("R7 no write", 2); chk_drop("R7 counted once");
    pkt(h0(2'b10, 5'd0, 0, 10'd1), h1(4'h0, 4'hF), ad(2), 32'h88888888);
    apply(2, 4'hF, 32'h88888888);
    chk_reg("R7 recovers", 2);
  endtask

  task automatic t_abort();
    beat(1, 0, h0(2'b10, 5'd0, 0, 10'd1)); beat(0, 0, h1(4'h0, 4'hF));
    pkt(h0(2'b10, 5'd0, 0, 10'd1), h1(4'h0, 4'hF), ad(3), 32'h9ABCDEF0); bump();
    apply(3, 4'hF, 32'h9ABCDEF0);
    chk_reg("R8 restart write", 3); chk_drop("R8 abort counted");
  endtask

  task automatic t_gaps_and_stray();
    beat(0, 0, h0(2'b10, 5'd0, 0, 10'd1)); beat(0, 0, h1(4'h0, 4'hF));
    beat(0, 0, ad(4)); beat(0, 1, 32'h13579BDF); gap();
    chk_reg("R9 stray beats", 4); chk_drop("R9 stray not counted");
    beat(1, 0, h0(2'b10, 5'd0, 0, 10'd1)); gap(); gap();
    beat(0, 0, h1(4'h0, 4'b1100)); gap();
    beat(0, 0, ad(4)); gap(); gap();
    beat(0, 1, 32'h2468ACE0); gap();
    apply(4, 4'b1100, 32'h2468ACE0);
    chk_reg("R9 gapped write", 4); chk_drop("R9 gaps no drop");
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 12; k++) begin
      pkt(h0(2'b10, 5'd0, 1, 10'd1), h1(4'h0, 4'hF), ad(6), 32'h0);
      bump();
    end
    chk_drop("R10 saturated");
    check("R10 all ones", {28'd0, drop_count}, 32'd15);
    chk_reg("R11 reg6 untouched", 6);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_write();
    t_lanes();
    t_zero_be();
    t_window();
    t_bad_headers();
    t_missing_eop();
    t_abort();
    t_gaps_and_stray();
    t_saturate();
    for (int i = 0; i < 64; i++) chk_reg("R11 final sweep", i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule